// File: doc/BRIEF.md
# Multi-Window Sliding Window Generator

This block turns a raster stream of image pixels, arriving several pixels per clock, into square neighbourhoods ready for a filter bank. Each accepted input word carries `NUM_LANES` horizontally adjacent pixels of one image row. For every lane the block produces the `WIN`x`WIN` window whose bottom-right corner is that lane's pixel. The result is up to `NUM_LANES` overlapping windows per cycle, each with its own valid flag.

Pixel data is never fetched twice. The previous `WIN-1` image rows are held in plain shift-register row delays, which are written and read only at fixed ends and have no selection multiplexers. A coalescer keeps the last `WIN-1` columns of the preceding word, so that windows crossing a word boundary are complete. A window is flagged valid only when it lies entirely inside the current frame. Back-pressure from the consumer stalls the whole pipeline without losing or repeating data.

Top module: `sliding_window_gen`

## Requirements
- R1: While reset is asserted and after it is released, all `outWinValid` flags are 0 until the first word has been accepted.
- R2: A word is accepted on a rising edge where `inValid` and `outReady` are both 1, and its windows appear on the outputs after that same edge. Lane `p` of `inPix` (bits `[p*PIX_W +: PIX_W]`) is image column `x0+p`, where `x0` is the first column of the word. Element (row `k`, column `j`) of window `i` sits at `outWin[((i*WIN+k)*WIN+j)*PIX_W +: PIX_W]`, with row 0 at the top and column 0 at the left. It holds the pixel at image row `r-(WIN-1)+k` and column `x0+i-(WIN-1)+j`, where `r` is the row of the word.
- R3: Rows `k < WIN-1` of every valid window hold the pixels of the `WIN-1` previously received image rows at the same columns, taken from internal storage.
- R4: Columns of a valid window that lie left of the current word are taken from the previously accepted word(s) of the same row.
- R5: Window `i` is flagged valid only if its column `x0+i` is at least `WIN-1` and its row is at least `WIN-1`. Windows that would wrap across a row start are flagged invalid.
- R6: For words in the first `WIN-1` rows of a frame, all flags are 0.
- R7: After `IMG_H` rows the row count restarts at 0 for the next frame, and R6 applies again to the new frame.
- R8: While `outReady` is 0, `inReady` is 0 and the outputs (flags and windows) hold their values.
- R9: On an edge with `outReady` 1 and `inValid` 0, all flags become 0.
- R10: Every valid window is presented exactly once. Each frame yields `(IMG_H-WIN+1)*(IMG_W-WIN+1)` valid windows regardless of gaps in `inValid` or stalls on `outReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is present |
| inReady | output | 1 | Block can take a word this cycle |
| inPix | input | NUM_LANES*PIX_W | Input word, lane 0 leftmost |
| outReady | input | 1 | Consumer takes the presented windows |
| outWinValid | output | NUM_LANES | Per-window valid flag |
| outWin | output | NUM_LANES*WIN*WIN*PIX_W | Window contents |

## Verification
First, a gap-free stream over two frames shows that the window contents and lane mapping are correct. It also exercises the masking of the top rows and of the row-start columns, and the restart at a frame edge. Next, randomly gapped input words show whether the row delays and column history advance only on accepted words; a window-count comparison over those frames then catches lost or duplicated windows. Last, random output stalls mixed with input gaps tell a correct hold apart from an output that drifts or clears while stalled. They also separate the clear on an idle accepted cycle from the hold.

// File: rtl/swg_pkg.sv
package swg_pkg;
  typedef struct packed {
    logic shift;   // advance row delays and column history
    logic load;    // capture fresh windows into the output register
    logic clear;   // consumer took data, nothing new arrived
  } swgStrobe_t;
endpackage

// File: rtl/swg_row_delay.sv
module swg_row_delay #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (shiftEn) begin
      stage[0] <= din;
      for (int d = 1; d < DEPTH; d++) stage[d] <= stage[d-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/swg_coalescer.sv
module swg_coalescer #(
  parameter int NUM_LANES = 4,
  parameter int WIN       = 3,
  parameter int PIX_W     = 8,
  localparam int HIST     = WIN - 1,
  localparam int EXT      = NUM_LANES + WIN - 1,
  localparam int COL_BITS = NUM_LANES * WIN * PIX_W,
  localparam int OUT_BITS = NUM_LANES * WIN * WIN * PIX_W
) (
  input  logic                clk,
  input  logic                load,
  input  logic [COL_BITS-1:0] colFlat,
  output logic [OUT_BITS-1:0] winFlat
);
  logic [PIX_W-1:0] hist [HIST][WIN];
  logic [PIX_W-1:0] ext  [EXT][WIN];
  logic [OUT_BITS-1:0] winReg;

  for (genvar e = 0; e < EXT; e++) begin : g_ext
    for (genvar k = 0; k < WIN; k++) begin : g_row
      if (e < HIST) begin : g_old
        assign ext[e][k] = hist[e][k];
      end else begin : g_new
        assign ext[e][k] = colFlat[((e-HIST)*WIN+k)*PIX_W +: PIX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int h = 0; h < HIST; h++)
        for (int k = 0; k < WIN; k++)
          hist[h][k] <= ext[NUM_LANES+h][k];
      for (int i = 0; i < NUM_LANES; i++)
        for (int k = 0; k < WIN; k++)
          for (int j = 0; j < WIN; j++)
            winReg[((i*WIN+k)*WIN+j)*PIX_W +: PIX_W] <= ext[i+j][k];
    end
  end

  assign winFlat = winReg;
endmodule

// File: rtl/swg_datapath.sv
module swg_datapath
  import swg_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WIN       = 3,
  parameter int PIX_W     = 8,
  parameter int IMG_W     = 16,
  localparam int WORD_W   = NUM_LANES * PIX_W,
  localparam int WPR      = IMG_W / NUM_LANES,
  localparam int LINES    = WIN - 1,
  localparam int COL_BITS = NUM_LANES * WIN * PIX_W,
  localparam int OUT_BITS = NUM_LANES * WIN * WIN * PIX_W
) (
  input  logic                clk,
  input  swgStrobe_t          strobe,
  input  logic [WORD_W-1:0]   inPix,
  output logic [OUT_BITS-1:0] outWin
);
  logic [WORD_W-1:0] lineIn  [LINES];
  logic [WORD_W-1:0] lineOut [LINES];
  logic [COL_BITS-1:0] colFlat;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    if (l == 0) begin : g_first
      assign lineIn[l] = inPix;
    end else begin : g_chain
      assign lineIn[l] = lineOut[l-1];
    end
    swg_row_delay #(.WORD_W(WORD_W), .DEPTH(WPR)) i_delay (
      .clk    (clk),
      .shiftEn(strobe.shift),
      .din    (lineIn[l]),
      .dout   (lineOut[l])
    );
  end

  // column stacks: row WIN-1 is the live word, older rows come from the delays
  for (genvar c = 0; c < NUM_LANES; c++) begin : g_col
    for (genvar k = 0; k < WIN; k++) begin : g_stack
      if (k == WIN-1) begin : g_live
        assign colFlat[(c*WIN+k)*PIX_W +: PIX_W] = inPix[c*PIX_W +: PIX_W];
      end else begin : g_held
        assign colFlat[(c*WIN+k)*PIX_W +: PIX_W] = lineOut[WIN-2-k][c*PIX_W +: PIX_W];
      end
    end
  end

  swg_coalescer #(.NUM_LANES(NUM_LANES), .WIN(WIN), .PIX_W(PIX_W)) i_coal (
    .clk    (clk),
    .load   (strobe.load),
    .colFlat(colFlat),
    .winFlat(outWin)
  );
endmodule

// File: rtl/swg_ctrl.sv
module swg_ctrl
  import swg_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WIN       = 3,
  parameter int IMG_W     = 16,
  parameter int IMG_H     = 8,
  localparam int WPR      = IMG_W / NUM_LANES,
  localparam int COL_W    = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int ROW_W    = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 outReady,
  output logic                 inReady,
  output swgStrobe_t           strobe,
  output logic [NUM_LANES-1:0] outWinValid
);
  logic [COL_W-1:0] colIdx;
  logic [ROW_W-1:0] rowIdx;
  logic [NUM_LANES-1:0] posMask;
  logic [NUM_LANES-1:0] flagReg;
  logic fire;
  logic rowOk;

  assign fire    = inValid & outReady;
  assign inReady = outReady;

  always_comb begin
    strobe.shift = fire;
    strobe.load  = fire;
    strobe.clear = outReady & ~inValid;
  end

  assign rowOk = int'(rowIdx) >= WIN - 1;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_mask
    assign posMask[i] = rowOk && ((int'(colIdx) * NUM_LANES + i) >= WIN - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colIdx <= '0;
      rowIdx <= '0;
    end else if (fire) begin
      if (colIdx == COL_W'(WPR-1)) begin
        colIdx <= '0;
        rowIdx <= (rowIdx == ROW_W'(IMG_H-1)) ? '0 : rowIdx + 1'b1;
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagReg <= '0;
    else if (strobe.load)  flagReg <= posMask;
    else if (strobe.clear) flagReg <= '0;
  end

  assign outWinValid = flagReg;
endmodule

// File: rtl/sliding_window_gen.sv
module sliding_window_gen
  import swg_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WIN       = 3,
  parameter int PIX_W     = 8,
  parameter int IMG_W     = 16,
  parameter int IMG_H     = 8,
  localparam int OUT_BITS = NUM_LANES * WIN * WIN * PIX_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [NUM_LANES*PIX_W-1:0] inPix,
  input  logic                       outReady,
  output logic [NUM_LANES-1:0]       outWinValid,
  output logic [OUT_BITS-1:0]        outWin
);
  swgStrobe_t strobe;

  swg_ctrl #(.NUM_LANES(NUM_LANES), .WIN(WIN), .IMG_W(IMG_W), .IMG_H(IMG_H)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .strobe     (strobe),
    .outWinValid(outWinValid)
  );

  swg_datapath #(.NUM_LANES(NUM_LANES), .WIN(WIN), .PIX_W(PIX_W), .IMG_W(IMG_W)) i_dp (
    .clk   (clk),
    .strobe(strobe),
    .inPix (inPix),
    .outWin(outWin)
  );
endmodule

// File: rtl/swg_checker.sv
module swg_checker #(
  parameter int NUM_LANES = 4,
  parameter int WIN       = 3,
  parameter int PIX_W     = 8,
  parameter int IMG_W     = 16,
  parameter int IMG_H     = 8,
  localparam int OUT_BITS = NUM_LANES * WIN * WIN * PIX_W,
  localparam int WPR      = IMG_W / NUM_LANES
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic                 outReady,
  input logic [NUM_LANES-1:0] outWinValid,
  input logic [OUT_BITS-1:0]  outWin
);
  int  chkCol;
  int  chkRow;
  logic seenWord;
  logic accept;

  assign accept = inValid && inReady;

  // independent word/row position tracker, wraps per frame (R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkCol   <= 0;
      chkRow   <= 0;
      seenWord <= 1'b0;
    end else if (accept) begin
      seenWord <= 1'b1;
      if (chkCol == WPR - 1) begin
        chkCol <= 0;
        chkRow <= (chkRow == IMG_H - 1) ? 0 : chkRow + 1;
      end else begin
        chkCol <= chkCol + 1;
      end
    end
  end

  // R1: no flag before the first accepted word
  always @(posedge clk) begin
    if (rstN && !seenWord) begin
      a_r1_reset_clear: assert (outWinValid == '0);
    end
  end

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |=> ($stable(outWinValid) && $stable(outWin)));

  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && !inValid) |=> (outWinValid == '0));

  a_r6_top_rows: assert property (@(posedge clk) disable iff (!rstN)
    (accept && chkRow < WIN - 1) |=> (outWinValid == '0));

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    a_r5_row_start: assert property (@(posedge clk) disable iff (!rstN)
      (accept && (chkCol * NUM_LANES + i < WIN - 1)) |=> !outWinValid[i]);
    a_r5_inside: assert property (@(posedge clk) disable iff (!rstN)
      (accept && chkRow >= WIN - 1 && (chkCol * NUM_LANES + i >= WIN - 1)) |=> outWinValid[i]);
  end

  // R2: neighbouring valid windows share all but one column
  for (genvar i = 0; i + 1 < NUM_LANES; i++) begin : g_pair
    for (genvar k = 0; k < WIN; k++) begin : g_r
      for (genvar j = 0; j + 1 < WIN; j++) begin : g_c
        a_r2_overlap: assert property (@(posedge clk) disable iff (!rstN)
          (outWinValid[i] && outWinValid[i+1]) |->
          (outWin[((i*WIN+k)*WIN+j+1)*PIX_W +: PIX_W] ==
           outWin[(((i+1)*WIN+k)*WIN+j)*PIX_W +: PIX_W]));
      end
    end
  end
endmodule

bind sliding_window_gen swg_checker #(
  .NUM_LANES(NUM_LANES), .WIN(WIN), .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)
) i_swg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .outReady   (outReady),
  .outWinValid(outWinValid),
  .outWin     (outWin)
);

// File: tb/test_sliding_window_gen.sv
`timescale 1ns/1ps
module test_sliding_window_gen;
  localparam int P   = 4;
  localparam int K   = 3;
  localparam int PW  = 8;
  localparam int W   = 16;
  localparam int H   = 8;
  localparam int WPR = W / P;
  localparam int OB  = P * K * K * PW;
  localparam int WIN_PER_FRAME = (H - K + 1) * (W - K + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [P*PW-1:0] inPix = '0;
  logic outReady = 1'b0;
  logic [P-1:0] outWinValid;
  logic [OB-1:0] outWin;

  always #2 clk = ~clk;

  sliding_window_gen i_sliding_window_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .outReady(outReady), .outWinValid(outWinValid), .outWin(outWin)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int frameB = 0, rowB = 0, colB = 0;
  int consumed = 0;
  bit expValid [P];
  int expWin [P][K][K];
  string expTag = "R1";

  function automatic int pixVal(int f, int r, int c);
    return (f * 97 + r * 29 + c * 11 + 5) % 256;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishRun();
      end
    end
  end

  // compare outputs with the model state, at the negative edge
  task automatic compareOut();
    for (int i = 0; i < P; i++) begin
      check(expTag, int'(outWinValid[i]), int'(expValid[i]), $sformatf("flag lane %0d", i));
      if (expValid[i] && outWinValid[i]) begin
        for (int k = 0; k < K; k++)
          for (int j = 0; j < K; j++) begin
            string t;
            if (k < K - 1) t = "R3";
            else if (i + j < K - 1) t = "R4";
            else t = "R2";
            check(t, int'(outWin[((i*K+k)*K+j)*PW +: PW]), expWin[i][k][j],
                  $sformatf("window %0d elem %0d,%0d", i, k, j));
          end
      end
    end
  endtask

  // one cycle: check, drive, update model for the coming edge
  task automatic stepCycle(bit wantValid, bit wantReady);
    @(negedge clk);
    compareOut();
    if (wantReady)
      for (int i = 0; i < P; i++) consumed += int'(outWinValid[i]);
    inValid  = wantValid;
    outReady = wantReady;
    for (int p = 0; p < P; p++) inPix[p*PW +: PW] = PW'(pixVal(frameB, rowB, colB * P + p));
    #0.5;
    check("R8", int'(inReady), int'(wantReady), "input ready follows output ready");
    if (wantValid && wantReady) begin
      for (int i = 0; i < P; i++) begin
        int x = colB * P + i;
        expValid[i] = (x >= K - 1) && (rowB >= K - 1);
        for (int k = 0; k < K; k++)
          for (int j = 0; j < K; j++)
            expWin[i][k][j] = pixVal(frameB, rowB - (K - 1) + k, x - (K - 1) + j);
      end
      if (rowB < K - 1) expTag = (frameB > 0) ? "R7" : "R6";
      else expTag = "R5";
      colB++;
      if (colB == WPR) begin
        colB = 0;
        rowB++;
        if (rowB == H) begin rowB = 0; frameB++; end
      end
    end else if (wantReady) begin
      for (int i = 0; i < P; i++) expValid[i] = 1'b0;
      expTag = "R9";
    end else begin
      expTag = "R8";
    end
  endtask

  task automatic runWords(int nWords, int validPct, int readyPct);
    int taken = 0;
    while (taken < nWords) begin
      bit v = ($urandom_range(99) < validPct);
      bit r = ($urandom_range(99) < readyPct);
      if (v && r) taken++;
      stepCycle(v, r);
    end
  endtask

  initial begin
    for (int i = 0; i < P; i++) expValid[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(outWinValid), 0, "flags during reset");
    rstN = 1'b1;
    stepCycle(1'b0, 1'b0);
    stepCycle(1'b0, 1'b1);
    expTag = "R1";
    stepCycle(1'b0, 1'b1);

    // gap-free stream, two frames
    runWords(2 * H * WPR, 100, 100);
    stepCycle(1'b0, 1'b1);

    // gapped input, two frames, window count
    consumed = 0;
    runWords(2 * H * WPR, 50, 100);
    stepCycle(1'b0, 1'b1);
    stepCycle(1'b0, 1'b1);
    check("R10", consumed, 2 * WIN_PER_FRAME, "windows presented over gapped frames");

    // stalls and gaps, two frames
    consumed = 0;
    runWords(2 * H * WPR, 70, 60);
    stepCycle(1'b0, 1'b1);
    stepCycle(1'b0, 1'b1);
    check("R10", consumed, 2 * WIN_PER_FRAME, "windows presented over stalled frames");

    finishRun();
  end
endmodule